// File: doc/BRIEF.md
# Dual-Channel Converter Register Controller

This block sits behind a serial frame decoder and keeps the register state for two converter channels. Each complete frame arrives as a one-cycle strobe with a 3-bit command, a 3-bit channel address and a 16-bit data word. Each channel has a staging (input) register and a live (output) register. The output register drives the converter code.

Commands can do the following:

- stage a code;
- promote a staged code;
- stage a code and then promote every channel;
- write straight through to the output.

Other commands set the power-down modes, clear the block, load a per-channel auto-update mask and switch the internal reference. An active-low load pin gives a hardware path that promotes the staged codes of every channel that is not masked. The analog stage and the reference circuit are outside the block.

Top module: `dac_regctl`

## Requirements
- R1: While `rst` is high, and after it is released, all codes, the power-down field, the reference enable and the auto-update mask are zero.
- R2: A cycle with `frm_valid` low changes no register. If `load_n` also sees no falling edge, all outputs stay stable.
- R3: Address 000 selects channel A (bits [15:0] of `out_codes`). Address 001 selects channel B (bits [31:16]). Address 111 selects both. Any other address makes commands 000 to 011 have no effect.
- R4: Command 000 stores the data in the staging register of each selected channel. The output of a selected channel changes only if its mask bit is set, and then it takes the data.
- R5: Command 001 copies the staging register of each selected channel into its output register.
- R6: Command 010 stores the data in the selected staging registers. Every channel's output then takes its updated staging value.
- R7: Command 011 writes the data into both the staging and the output register of each selected channel.
- R8: Command 100 applies mode `data[5:4]` to each channel whose select bit `data[ch]` is set. Channel ch's mode appears on `pd_mode[2ch+1:2ch]`. The encodings are 00 normal, 01 1k to ground, 10 100k to ground and 11 high impedance.
- R9: Command 101 clears all staging and output registers, the mask and the power-down field. The reference enable is kept.
- R10: Command 110 loads the mask from `data[1:0]` (bit ch for channel ch).
- R11: Command 111 sets the reference enable to `data[0]`.
- R12: A high-to-low transition of `load_n` copies staging to output for every unmasked channel. The copy takes effect at the first clock edge that samples the pin low after it was sampled high. Keeping the pin low causes no further copies, and masked channels ignore it.
- R13: When a frame and a load edge meet on the same clock edge, the load copies the staging values held before that edge. Any output write made by the frame itself wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe marking a complete frame |
| frm_cmd | input | 3 | Frame command |
| frm_addr | input | 3 | Frame channel address |
| frm_data | input | 16 | Frame data word |
| load_n | input | 1 | Active-low hardware load, acting on its falling edge |
| out_codes | output | 32 | Live codes, channel B in bits [31:16], channel A in bits [15:0] |
| pd_mode | output | 4 | Two power-down mode bits per channel |
| ref_en | output | 1 | Internal reference enable |

## Verification
The hardest states to reach from the ports are those where staging and live codes differ while the mask is in a chosen pattern. Command 000 and the load pin only show their effect in that situation.

Before each target frame, the bench builds that situation with a fixed preamble:

- clear the mask;
- write distinct through-codes to both channels;
- stage different codes;
- load the mask under test.

It then sweeps every command from 000 to 011 against all eight addresses and all four masks. Load edges are placed both alone and on the same edge as a staging frame, which exercises the precedence rule.

// File: rtl/dac_regctl_pkg.sv
package dac_regctl_pkg;

    typedef enum logic [2:0] {
        CMD_STAGE      = 3'b000,
        CMD_PROMOTE    = 3'b001,
        CMD_STAGE_ALL  = 3'b010,
        CMD_WRITE_THRU = 3'b011,
        CMD_POWER      = 3'b100,
        CMD_CLEAR      = 3'b101,
        CMD_MASK       = 3'b110,
        CMD_REFERENCE  = 3'b111
    } dac_cmd_e;

    typedef enum logic [1:0] {
        PWR_NORMAL = 2'b00,
        PWR_1K     = 2'b01,
        PWR_100K   = 2'b10,
        PWR_HIZ    = 2'b11
    } pwr_mode_e;

    localparam logic [2:0] ADDR_BROADCAST = 3'b111;
    localparam int         PWR_MODE_LSB   = 4;

    typedef struct packed {
        logic stage;    // load staging register from data
        logic thru;     // load output register from data
        logic promote;  // load output register from staging
    } chan_ctl_t;

    function automatic logic [7:0] addr_select(input logic [2:0] addr, input int nch);
        logic [7:0] sel;
        sel = '0;
        if (addr == ADDR_BROADCAST) begin
            for (int i = 0; i < nch; i++) sel[i] = 1'b1;
        end else if (int'(addr) < nch) begin
            sel[addr] = 1'b1;
        end
        return sel;
    endfunction

endpackage

// File: rtl/dac_frame_dec.sv
module dac_frame_dec
    import dac_regctl_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 16
) (
    input  logic                  frm_valid,
    input  logic [2:0]            frm_cmd,
    input  logic [2:0]            frm_addr,
    input  logic [DW-1:0]         frm_data,
    input  logic [NCH-1:0]        mask,
    output chan_ctl_t [NCH-1:0]   ctl,
    output logic                  clear,
    output logic [NCH-1:0]        pwr_ld,
    output logic                  mask_ld,
    output logic                  ref_ld
);
    logic [7:0]     sel_full;
    logic [NCH-1:0] sel;

    always_comb begin
        sel_full = addr_select(frm_addr, NCH);
        sel      = sel_full[NCH-1:0];
    end

    always_comb begin
        ctl     = '0;
        clear   = 1'b0;
        pwr_ld  = '0;
        mask_ld = 1'b0;
        ref_ld  = 1'b0;
        if (frm_valid) begin
            unique case (dac_cmd_e'(frm_cmd))
                CMD_STAGE: begin
                    for (int ch = 0; ch < NCH; ch++) begin
                        ctl[ch].stage = sel[ch];
                        ctl[ch].thru  = sel[ch] & mask[ch];
                    end
                end
                CMD_PROMOTE: begin
                    for (int ch = 0; ch < NCH; ch++) ctl[ch].promote = sel[ch];
                end
                CMD_STAGE_ALL: begin
                    if (|sel) begin
                        for (int ch = 0; ch < NCH; ch++) begin
                            ctl[ch].stage   = sel[ch];
                            ctl[ch].thru    = sel[ch];
                            ctl[ch].promote = ~sel[ch];
                        end
                    end
                end
                CMD_WRITE_THRU: begin
                    for (int ch = 0; ch < NCH; ch++) begin
                        ctl[ch].stage = sel[ch];
                        ctl[ch].thru  = sel[ch];
                    end
                end
                CMD_POWER:     pwr_ld  = frm_data[NCH-1:0];
                CMD_CLEAR:     clear   = 1'b1;
                CMD_MASK:      mask_ld = 1'b1;
                CMD_REFERENCE: ref_ld  = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
    import dac_regctl_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  chan_ctl_t     ctl,
    input  logic          hw_load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] live_q
);
    logic [DW-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            stage_q <= '0;
            live_q  <= '0;
        end else begin
            if (ctl.stage) stage_q <= din;
            if (ctl.thru)
                live_q <= din;
            else if (ctl.promote || hw_load)
                live_q <= stage_q;
        end
    end
endmodule

// File: rtl/dac_cfg_regs.sv
module dac_cfg_regs
    import dac_regctl_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [NCH-1:0]   pwr_ld,
    input  logic             mask_ld,
    input  logic             ref_ld,
    input  logic [DW-1:0]    din,
    output logic [NCH-1:0]   mask,
    output logic [2*NCH-1:0] pwr,
    output logic             ref_en
);
    pwr_mode_e new_mode;
    assign new_mode = pwr_mode_e'(din[PWR_MODE_LSB +: 2]);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_pwr
        always_ff @(posedge clk) begin
            if (rst || clear)
                pwr[2*ch +: 2] <= PWR_NORMAL;
            else if (pwr_ld[ch])
                pwr[2*ch +: 2] <= new_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            mask <= '0;
        else if (mask_ld)
            mask <= din[NCH-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ref_en <= 1'b0;
        else if (ref_ld)
            ref_en <= din[0];
    end
endmodule

// File: rtl/dac_regctl.sv
module dac_regctl
    import dac_regctl_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  logic [2:0]        frm_cmd,
    input  logic [2:0]        frm_addr,
    input  logic [DW-1:0]     frm_data,
    input  logic              load_n,
    output logic [NCH*DW-1:0] out_codes,
    output logic [2*NCH-1:0]  pd_mode,
    output logic              ref_en
);
    chan_ctl_t [NCH-1:0] ctl;
    logic                clear;
    logic [NCH-1:0]      pwr_ld;
    logic                mask_ld;
    logic                ref_ld;
    logic [NCH-1:0]      mask;
    logic                load_n_q;
    logic                load_fall;

    always_ff @(posedge clk) begin
        if (rst) load_n_q <= 1'b1;
        else     load_n_q <= load_n;
    end
    assign load_fall = load_n_q & ~load_n;

    dac_frame_dec #(.NCH(NCH), .DW(DW)) u_dec (
        .frm_valid (frm_valid),
        .frm_cmd   (frm_cmd),
        .frm_addr  (frm_addr),
        .frm_data  (frm_data),
        .mask      (mask),
        .ctl       (ctl),
        .clear     (clear),
        .pwr_ld    (pwr_ld),
        .mask_ld   (mask_ld),
        .ref_ld    (ref_ld)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        dac_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .clear   (clear),
            .ctl     (ctl[ch]),
            .hw_load (load_fall & ~mask[ch]),
            .din     (frm_data),
            .live_q  (out_codes[ch*DW +: DW])
        );
    end

    dac_cfg_regs #(.NCH(NCH), .DW(DW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .pwr_ld  (pwr_ld),
        .mask_ld (mask_ld),
        .ref_ld  (ref_ld),
        .din     (frm_data),
        .mask    (mask),
        .pwr     (pd_mode),
        .ref_en  (ref_en)
    );
endmodule

// File: rtl/dac_regctl_chk.sv
module dac_regctl_chk #(
    parameter int NCH = 2,
    parameter int DW  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              frm_valid,
    input logic [2:0]        frm_cmd,
    input logic [2:0]        frm_addr,
    input logic [DW-1:0]     frm_data,
    input logic              load_n,
    input logic [NCH*DW-1:0] out_codes,
    input logic [2*NCH-1:0]  pd_mode,
    input logic              ref_en
);
    logic addr_reserved;
    assign addr_reserved = (frm_addr != 3'b111) && (int'(frm_addr) >= NCH);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (out_codes == '0 && pd_mode == '0 && ref_en == 1'b0));

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!frm_valid && load_n) |=> ($stable(out_codes) && $stable(pd_mode) && $stable(ref_en)));

    // R3
    reserved_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_cmd[2] && addr_reserved && load_n) |=> $stable(out_codes));

    // R7
    write_thru_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_cmd == 3'b011 && frm_addr == 3'b000)
            |=> out_codes[DW-1:0] == $past(frm_data));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_cmd == 3'b101) |=> (out_codes == '0 && pd_mode == '0 && $stable(ref_en)));

    // R11
    reference_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_cmd == 3'b111) |=> ref_en == $past(frm_data[0]));
endmodule

bind dac_regctl dac_regctl_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_valid (frm_valid),
    .frm_cmd   (frm_cmd),
    .frm_addr  (frm_addr),
    .frm_data  (frm_data),
    .load_n    (load_n),
    .out_codes (out_codes),
    .pd_mode   (pd_mode),
    .ref_en    (ref_en)
);

// File: tb/dac_regctl_tb.sv
`timescale 1ns/1ps
module dac_regctl_tb;
    localparam int NCH = 2;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frm_valid = 1'b0;
    logic [2:0]        frm_cmd = '0;
    logic [2:0]        frm_addr = '0;
    logic [DW-1:0]     frm_data = '0;
    logic              load_n = 1'b1;
    logic [NCH*DW-1:0] out_codes;
    logic [2*NCH-1:0]  pd_mode;
    logic              ref_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] m_stage [NCH];
    logic [DW-1:0] m_live  [NCH];
    logic [1:0]    m_pwr   [NCH];
    logic [NCH-1:0] m_mask;
    logic          m_ref;

    always #2.5 clk = ~clk;

    dac_regctl #(.NCH(NCH), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_cmd(frm_cmd),
        .frm_addr(frm_addr), .frm_data(frm_data), .load_n(load_n),
        .out_codes(out_codes), .pd_mode(pd_mode), .ref_en(ref_en)
    );

    function automatic string tag_of(input int cmd);
        case (cmd)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            5: return "R9";
            6: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [NCH-1:0] sel_of(input logic [2:0] a);
        if (a == 3'd0) return 2'b01;
        if (a == 3'd1) return 2'b10;
        if (a == 3'd7) return 2'b11;
        return 2'b00;
    endfunction

    task automatic model_frame(input int cmd, input logic [2:0] a, input logic [DW-1:0] d);
        logic [NCH-1:0] s;
        s = sel_of(a);
        case (cmd)
            0: for (int c = 0; c < NCH; c++) if (s[c]) begin
                   m_stage[c] = d;
                   if (m_mask[c]) m_live[c] = d;
               end
            1: for (int c = 0; c < NCH; c++) if (s[c]) m_live[c] = m_stage[c];
            2: if (s != 0) begin
                   for (int c = 0; c < NCH; c++) if (s[c]) m_stage[c] = d;
                   for (int c = 0; c < NCH; c++) m_live[c] = m_stage[c];
               end
            3: for (int c = 0; c < NCH; c++) if (s[c]) begin
                   m_stage[c] = d; m_live[c] = d;
               end
            4: for (int c = 0; c < NCH; c++) if (d[c]) m_pwr[c] = d[5:4];
            5: begin
                   for (int c = 0; c < NCH; c++) begin
                       m_stage[c] = '0; m_live[c] = '0; m_pwr[c] = 2'b00;
                   end
                   m_mask = '0;
               end
            6: m_mask = d[NCH-1:0];
            default: m_ref = d[0];
        endcase
    endtask

    task automatic check_all(input string req);
        logic [NCH*DW-1:0] exp_codes;
        logic [2*NCH-1:0]  exp_pd;
        for (int c = 0; c < NCH; c++) begin
            exp_codes[c*DW +: DW] = m_live[c];
            exp_pd[2*c +: 2]      = m_pwr[c];
        end
        checks++;
        if (out_codes !== exp_codes || pd_mode !== exp_pd || ref_en !== m_ref) begin
            fails++;
            $display("FAIL %s: codes=%h pd=%b ref=%b expected codes=%h pd=%b ref=%b",
                     req, out_codes, pd_mode, ref_en, exp_codes, exp_pd, m_ref);
        end
    endtask

    // drive one frame, let it land, update model, compare
    task automatic frame(input int cmd, input logic [2:0] a, input logic [DW-1:0] d, input string req);
        @(negedge clk);
        frm_valid = 1'b1; frm_cmd = 3'(cmd); frm_addr = a; frm_data = d;
        @(negedge clk);
        frm_valid = 1'b0;
        model_frame(cmd, a, d);
        check_all(req);
    endtask

    task automatic model_load();
        for (int c = 0; c < NCH; c++) if (!m_mask[c]) m_live[c] = m_stage[c];
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_stage[c] = '0; m_live[c] = '0; m_pwr[c] = 2'b00;
        end
        m_mask = '0; m_ref = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R2: frame content without strobe
        @(negedge clk);
        frm_cmd = 3'd3; frm_addr = 3'd7; frm_data = 16'hBEEF;
        @(negedge clk);
        @(negedge clk);
        check_all("R2");

        // sweep channel commands over all addresses (R3) and masks
        for (int cmd = 0; cmd < 4; cmd++)
            for (int a = 0; a < 8; a++)
                for (int m = 0; m < 4; m++) begin
                    logic [DW-1:0] base;
                    base = 16'((cmd * 32 + a * 4 + m) * 5);
                    frame(6, 3'd0, 16'h0000, "R10");
                    frame(3, 3'd0, base + 16'h1000, "R7");
                    frame(3, 3'd1, base + 16'h2000, "R7");
                    frame(0, 3'd0, base + 16'h3000, "R4");
                    frame(0, 3'd1, base + 16'h4000, "R4");
                    frame(6, 3'd0, 16'(m), "R10");
                    frame(cmd, 3'(a), base + 16'h5000,
                          (a >= 2 && a < 7) ? "R3" : tag_of(cmd));
                end

        // R8: power-down select/mode sweep
        for (int s = 0; s < 4; s++)
            for (int md = 0; md < 4; md++)
                frame(4, 3'd5, 16'((md << 4) | s), "R8");

        // R11: reference on/off
        frame(7, 3'd0, 16'h0001, "R11");
        frame(7, 3'd0, 16'h0000, "R11");
        frame(7, 3'd2, 16'hFFFF, "R11");

        // R9: clear keeps reference
        frame(4, 3'd0, 16'h0033, "R8");
        frame(6, 3'd0, 16'h0003, "R10");
        frame(3, 3'd7, 16'h7777, "R7");
        frame(5, 3'd0, 16'h0000, "R9");
        frame(0, 3'd7, 16'h1234, "R9");  // mask cleared: output must not follow

        // R12: load pin per mask
        for (int m = 0; m < 4; m++) begin
            frame(6, 3'd0, 16'h0000, "R10");
            frame(3, 3'd0, 16'(16'h0A00 + m), "R7");
            frame(3, 3'd1, 16'(16'h0B00 + m), "R7");
            frame(0, 3'd0, 16'(16'h0C00 + m), "R4");
            frame(0, 3'd1, 16'(16'h0D00 + m), "R4");
            frame(6, 3'd0, 16'(m), "R10");
            @(negedge clk);
            load_n = 1'b0;
            @(negedge clk);
            model_load();
            check_all("R12");
            // held low: further staging must not propagate to unmasked channels
            frame(6, 3'd0, 16'h0000, "R10");
            frame(0, 3'd7, 16'(16'h0E00 + m), "R12");
            @(negedge clk);
            check_all("R12");
            load_n = 1'b1;
            @(negedge clk);
            check_all("R12");
        end

        // R13: stage frame and load edge on the same clock edge
        frame(6, 3'd0, 16'h0000, "R10");
        frame(0, 3'd7, 16'h4444, "R4");
        @(negedge clk);
        frm_valid = 1'b1; frm_cmd = 3'd0; frm_addr = 3'd0; frm_data = 16'h5555;
        load_n = 1'b0;
        @(negedge clk);
        frm_valid = 1'b0;
        model_load();
        model_frame(0, 3'd0, 16'h5555);
        check_all("R13");
        load_n = 1'b1;
        // write-through frame against load edge: frame value wins
        @(negedge clk);
        frm_valid = 1'b1; frm_cmd = 3'd3; frm_addr = 3'd1; frm_data = 16'h6666;
        load_n = 1'b0;
        @(negedge clk);
        frm_valid = 1'b0;
        model_load();
        model_frame(3, 3'd1, 16'h6666);
        check_all("R13");
        load_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule